// File: doc/BRIEF.md
# Status Change Event Register Bank

This block sits on the transceiver side of a ULPI link. It watches five single-bit status signals from the analog comparators: host disconnect, bus-voltage valid, session valid, session end and the ID-pin ground detect. Each input first passes through a small synchroniser. The bank then compares each synchronised value with its value one cycle earlier. When a low-to-high or high-to-low change occurs and the matching enable bit is set, the block raises a one-cycle notification pulse. The ULPI protocol front end uses that pulse to send a receive-command byte to the Link. The same event also sets a sticky latch bit, which stays set until software reads it.

Software reaches the bank through a plain address / write-data / read-data port that the protocol front end drives. There are two enable registers, one for rising edges and one for falling edges. Each has three addresses: a direct write, a bit-set and a bit-clear. A live status register and a clear-on-read latch register are read-only. The host-disconnect source counts only while the host-mode input is high.

Top module: `evt_bank`

## Requirements
- R1: The bit order in every register is host disconnect at bit 0, bus-voltage valid at bit 1, session valid at bit 2, session end at bit 3 and ID ground at bit 4. Reading address 0x13 returns the synchronised live value of each source. A change on `src_raw` is visible there after the second rising clock edge.
- R2: Bits 7:5 of every register read are always zero.
- R3: A rising edge on a source whose bit is set in the rising-enable register raises an event.
- R4: A falling edge on a source whose bit is set in the falling-enable register raises an event.
- R5: After reset, the rising-enable register reads 0x1E, the falling-enable register reads 0x1F, and the latch register reads 0x00.
- R6: While `host_mode` is low, bit 0 of the status register reads zero and edges on bit 0 raise no event.
- R7: An event sets its latch bit (address 0x14) one cycle after detection. The bit stays set until a read of address 0x14, and that read clears every latch bit on the same clock edge.
- R8: If an event occurs in the same cycle as a latch read, its latch bit remains set. The bits of the other sources are still cleared.
- R9: The rising-enable register sits at addresses 0x0D (write), 0x0E (set bits) and 0x0F (clear bits). The falling-enable register sits at 0x10 (write), 0x11 (set) and 0x12 (clear).
- R10: `evt_notify` is high for exactly one cycle, one cycle after an enabled edge is detected. It stays low when all matching enables are clear.
- R11: Writes to the status address (0x13) and the latch address (0x14) have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | High when the port acts as a host; gates the disconnect source |
| src_raw | input | 5 | Asynchronous status inputs from the comparators |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read of 0x14 clears the latch |
| reg_wdata | input | 5 | Write data (source bits only) |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| evt_notify | output | 1 | One-cycle request to send a receive command |

## Verification
A change on `src_raw` appears in the status register after two rising edges. The notification pulse and the latch bit follow one edge later, and the pulse drops after one more edge. The bench drives every input at the falling clock edge and counts whole cycles before each check, so each result is sampled at the falling edge where it first becomes due. Register writes are visible to the read that follows one edge later, because read data is combinational. The check for an event racing a clear aligns the latch read with the exact cycle in which the edge is detected.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NUM_SRC = 5;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 8;

  localparam logic [ADDR_W-1:0] RISE_BASE = 6'h0D;
  localparam logic [ADDR_W-1:0] FALL_BASE = 6'h10;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 6'h13;
  localparam logic [ADDR_W-1:0] LTCH_ADDR = 6'h14;

  localparam logic [NUM_SRC-1:0] RISE_RST = 5'b11110;
  localparam logic [NUM_SRC-1:0] FALL_RST = 5'b11111;

  // Enabled edge detection: rising where cur=1,prv=0; falling where cur=0,prv=1.
  function automatic logic [NUM_SRC-1:0] edge_hit(
      input logic [NUM_SRC-1:0] cur, input logic [NUM_SRC-1:0] prv,
      input logic [NUM_SRC-1:0] ren, input logic [NUM_SRC-1:0] fen);
    return (cur & ~prv & ren) | (~cur & prv & fen);
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [NUM_SRC-1:0] v);
    return {{(DATA_W-NUM_SRC){1'b0}}, v};
  endfunction
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/evt_edge.sv
module evt_edge
  import evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_mode,
  input  logic [NUM_SRC-1:0] cur,
  input  logic [NUM_SRC-1:0] rise_en,
  input  logic [NUM_SRC-1:0] fall_en,
  output logic [NUM_SRC-1:0] live,
  output logic [NUM_SRC-1:0] hit
);
  logic [NUM_SRC-1:0] prv_q;
  logic [NUM_SRC-1:0] gate;

  always_ff @(posedge clk) begin
    if (!rst_n) prv_q <= '0;
    else        prv_q <= cur;
  end

  // Bit 0 (host disconnect) only counts in host mode.
  assign gate = {{(NUM_SRC-1){1'b1}}, host_mode};
  assign live = cur & gate;
  assign hit  = edge_hit(cur, prv_q, rise_en, fall_en) & gate;
endmodule

// File: rtl/evt_enreg.sv
module evt_enreg
  import evt_pkg::*;
#(
  parameter logic [ADDR_W-1:0]  BASE = 6'h0D,
  parameter logic [NUM_SRC-1:0] RST  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] en
);
  localparam logic [ADDR_W-1:0] SET_ADDR = BASE + 6'd1;
  localparam logic [ADDR_W-1:0] CLR_ADDR = BASE + 6'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) en <= RST;
    else if (wr) begin
      if (addr == BASE)          en <= wdata;
      else if (addr == SET_ADDR) en <= en | wdata;
      else if (addr == CLR_ADDR) en <= en & ~wdata;
    end
  end

  assert_clear_drops_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CLR_ADDR) |=> ((en & $past(wdata)) == '0));
  assert_set_raises_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == SET_ADDR) |=> ((en & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/evt_bank.sv
module evt_bank
  import evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_mode,
  input  logic [NUM_SRC-1:0] src_raw,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               evt_notify
);
  logic [NUM_SRC-1:0] src_sync, live, hit, rise_en, fall_en, latch_q;
  logic               rd_latch;

  evt_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_async(src_raw), .q_sync(src_sync));

  evt_enreg #(.BASE(RISE_BASE), .RST(RISE_RST)) rise_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .en(rise_en));

  evt_enreg #(.BASE(FALL_BASE), .RST(FALL_RST)) fall_i (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .en(fall_en));

  evt_edge edge_i (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .cur(src_sync),
    .rise_en(rise_en), .fall_en(fall_en), .live(live), .hit(hit));

  assign rd_latch = reg_rd && (reg_addr == LTCH_ADDR);

  // New events win over a simultaneous clearing read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q    <= '0;
      evt_notify <= 1'b0;
    end else begin
      latch_q    <= (rd_latch ? '0 : latch_q) | hit;
      evt_notify <= |hit;
    end
  end

  always_comb begin
    unique case (reg_addr)
      RISE_BASE, RISE_BASE + 6'd1, RISE_BASE + 6'd2: reg_rdata = widen(rise_en);
      FALL_BASE, FALL_BASE + 6'd1, FALL_BASE + 6'd2: reg_rdata = widen(fall_en);
      STAT_ADDR: reg_rdata = widen(live);
      LTCH_ADDR: reg_rdata = widen(latch_q);
      default:   reg_rdata = '0;
    endcase
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NUM_SRC] == '0);
  assert_notify_after_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> evt_notify);
  assert_no_notify_without_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit) |=> !evt_notify);
  assert_latch_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_latch |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
  assert_host_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(host_mode) |-> !$rose(latch_q[0]));
endmodule

// File: tb/evt_bank_tb.sv
module evt_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_mode = 1'b1;
  logic [4:0] src_raw = '0;
  logic [5:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [4:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       evt_notify;
  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  evt_bank dut_i (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .src_raw(src_raw),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_notify(evt_notify));

  // {wr, addr[5:0], wdata[4:0], expected readback[7:0]}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 6'h0D, 5'h00, 8'h1E},
    {1'b0, 6'h10, 5'h00, 8'h1F},
    {1'b1, 6'h0D, 5'h1F, 8'h1F},
    {1'b1, 6'h0F, 5'h03, 8'h1C},
    {1'b1, 6'h0E, 5'h01, 8'h1D},
    {1'b1, 6'h10, 5'h00, 8'h00},
    {1'b1, 6'h11, 5'h0A, 8'h0A},
    {1'b1, 6'h12, 5'h02, 8'h08},
    {1'b1, 6'h13, 5'h1F, 8'h00},
    {1'b1, 6'h14, 5'h1F, 8'h00},
    {1'b1, 6'h0D, 5'h1E, 8'h1E},
    {1'b1, 6'h10, 5'h1F, 8'h1F}
  };

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [4:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  // Read with strobe; returns value seen before the clearing edge.
  task automatic rd_reg(input logic [5:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  // Drive a source change and check status / notify / latch timing.
  task automatic edge_case(input string req, input logic [4:0] nxt,
                           input logic [7:0] exp_stat, input logic exp_ntf,
                           input logic [7:0] exp_lat);
    logic [7:0] v;
    src_raw = nxt;
    tick();
    tick();
    reg_addr = 6'h13; #1;
    chk({req, " status"}, reg_rdata, exp_stat);
    chk({req, " notify early"}, {7'b0, evt_notify}, 8'h00);
    tick();
    chk({req, " notify"}, {7'b0, evt_notify}, {7'b0, exp_ntf});
    tick();
    chk({req, " notify width"}, {7'b0, evt_notify}, 8'h00);
    rd_reg(6'h14, v);
    chk({req, " latch"}, v, exp_lat);
  endtask

  initial begin
    logic [7:0] v;
    @(negedge clk); tick(); tick();
    rst_n = 1'b1;
    tick();
    // R5 reset state
    rd_reg(6'h14, v); chk("R5 latch reset", v, 8'h00);
    chk("R10 notify reset", {7'b0, evt_notify}, 8'h00);
    // R9 R2 R11 R5 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][19]) wr_reg(VEC[i][18:13], VEC[i][12:8]);
      rd_reg(VEC[i][18:13], v);
      chk($sformatf("R9/R11/R5 vector %0d", i), v, VEC[i][7:0]);
    end
    // R3 R1 rising on session valid (bit 2)
    edge_case("R3 R1 rise bit2", 5'b00100, 8'h04, 1'b1, 8'h04);
    // R4 falling on bit 2
    edge_case("R4 fall bit2", 5'b00000, 8'h00, 1'b1, 8'h04);
    // R1 R3 ID ground rise (bit 4), two sources together
    edge_case("R1 rise bits4,3", 5'b11000, 8'h18, 1'b1, 8'h18);
    edge_case("R4 fall bits4,3", 5'b00000, 8'h00, 1'b1, 8'h18);
    // R6 host disconnect in host mode: rise not enabled by default, fall is
    edge_case("R6 host rise masked", 5'b00001, 8'h01, 1'b0, 8'h00);
    edge_case("R6 host fall", 5'b00000, 8'h00, 1'b1, 8'h01);
    // R6 outside host mode
    host_mode = 1'b0;
    wr_reg(6'h0E, 5'h01);
    edge_case("R6 no host rise", 5'b00001, 8'h00, 1'b0, 8'h00);
    edge_case("R6 no host fall", 5'b00000, 8'h00, 1'b0, 8'h00);
    host_mode = 1'b1;
    // R10 masked: all enables cleared
    wr_reg(6'h0F, 5'h1F);
    wr_reg(6'h12, 5'h1F);
    edge_case("R10 masked rise", 5'b01110, 8'h0E, 1'b0, 8'h00);
    edge_case("R10 masked fall", 5'b00000, 8'h00, 1'b0, 8'h00);
    wr_reg(6'h0D, 5'h1E);
    wr_reg(6'h10, 5'h1F);
    // R7 latch holds until read
    src_raw = 5'b00010; tick(); tick(); tick(); tick(); tick();
    reg_addr = 6'h14; #1; chk("R7 latch held", reg_rdata, 8'h02);
    // R8 event in read cycle survives; old bit cleared
    src_raw = 5'b01010; tick(); tick();
    rd_reg(6'h14, v); chk("R8 read value", v, 8'h02);
    reg_addr = 6'h14; #1; chk("R8 event wins clear", reg_rdata, 8'h08);
    rd_reg(6'h14, v);
    reg_addr = 6'h14; #1; chk("R7 cleared by read", reg_rdata, 8'h00);
    // R11 write to latch address does not set bits
    wr_reg(6'h14, 5'h1F);
    reg_addr = 6'h14; #1; chk("R11 latch write ignored", reg_rdata, 8'h00);
    reg_addr = 6'h13; #1; chk("R11 status live", reg_rdata, 8'h0A);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule